// File: doc/BRIEF.md
# Dual Phase-Frequency Detector with Lock Monitor and Output Selector

This block holds the digital comparison side of a two-channel frequency synthesizer. Each channel compares a reference-divided pulse train against a feedback (main divider) pulse train. It issues current-source and current-sink requests to an analog charge pump that lies outside this block. A per-channel polarity bit matches the request sense to the slope of the oscillator. A per-channel tri-state bit silences both requests, and a per-channel power-down bit stops the channel. Each channel also qualifies its own lock. A channel counts as locked once several comparisons in a row have produced error pulses no wider than a small window. The lock indication then stays high and dips low only while an error pulse is active.

A single monitor pin is shared by both channels. A 4-bit selector chooses what drives it: either lock indication, both indications ANDed, the sampled reference or feedback level of either channel, or the serial shift-register output bit. Some selector codes drive the pin low. One code instead raises a divider-counter reset request. When both channels are powered down, the monitor pin is held low and the reference counters are told to stop.

All pulse inputs are sampled on the block clock, which must be much faster than the comparison rate. Request pulse widths are therefore measured in block clock cycles.

Top module: `pfd_lock_monitor`

## Requirements
- R1: A rising edge on a channel's reference input starts an "up" pulse, and a rising edge on its feedback input starts a "down" pulse. Once both have arrived, both end together, so the width of the surviving pulse equals the edge separation in clock cycles. Simultaneous edges give no pulse. A request output goes high after the second rising clock edge at which its input is seen high.
- R2: With the polarity bit at 1, the source output carries the up pulse and the sink output carries the down pulse. With the polarity bit at 0, the two outputs are exchanged.
- R3: With the tri-state bit at 1, both request outputs of that channel stay low for any input pattern.
- R4: With the power-down bit at 1, the channel's requests and lock indication stay low and its comparison state is cleared. After power-up, lock qualification starts from zero.
- R5: Lock rises after LOCK_CNT consecutive completed comparisons (default 4), each with a pulse width of at most LOCK_WIN cycles (default 2). It is low out of reset and after fewer good comparisons.
- R6: A completed comparison wider than LOCK_WIN clears lock and restarts the count, so LOCK_CNT new good comparisons are needed again.
- R7: While locked, the lock output is low exactly during the cycles in which that channel's up or down pulse is active, and is high otherwise.
- R8: The monitor selector s = {s3,s2,s1,s0} decodes as follows. 0100 gives lock 1, 0001 gives lock 2, and 0101 gives lock 1 AND lock 2. 1000 and 1100 give reference level 1, and 0010 and 0110 give reference level 2. 1001 and 1101 give feedback level 1, and 0011 and 0111 give feedback level 2. 1010 gives the serial data bit. The reference and feedback levels shown are the inputs after one clock of sampling.
- R9: Selector codes 0000, 1011, 1110 and 1111 drive the monitor output low. The counter reset request is high exactly when the selector is 1111.
- R10: With both channels powered down, the monitor output is low for every selector code and the reference-run output is low. Otherwise reference-run is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, samples all pulse inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| ref1_in | input | 1 | Channel 1 reference-divided pulse |
| fb1_in | input | 1 | Channel 1 feedback-divided pulse |
| ref2_in | input | 1 | Channel 2 reference-divided pulse |
| fb2_in | input | 1 | Channel 2 feedback-divided pulse |
| ch1_pol | input | 1 | Channel 1 polarity (1: up drives source) |
| ch1_hiz | input | 1 | Channel 1 requests forced inactive |
| ch1_off | input | 1 | Channel 1 power-down |
| ch2_pol | input | 1 | Channel 2 polarity |
| ch2_hiz | input | 1 | Channel 2 requests forced inactive |
| ch2_off | input | 1 | Channel 2 power-down |
| mon_sel | input | 4 | Monitor selector {s3,s2,s1,s0} |
| shift_dout | input | 1 | Serial shift-register output bit |
| ch1_src | output | 1 | Channel 1 current-source request |
| ch1_snk | output | 1 | Channel 1 current-sink request |
| ch2_src | output | 1 | Channel 2 current-source request |
| ch2_snk | output | 1 | Channel 2 current-sink request |
| ch1_lock | output | 1 | Channel 1 lock indication with error dips |
| ch2_lock | output | 1 | Channel 2 lock indication with error dips |
| mon_out | output | 1 | Shared monitor output |
| cnt_clear_req | output | 1 | Divider counter reset request |
| ref_run | output | 1 | Reference counters enabled |

## Verification
A stuck or misordered pulse latch shows at once as a request width that differs from the edge separation, or as the wrong output carrying the pulse, within two cycles of the lagging edge. A wrong lock counter shows as lock rising one comparison early or late, or failing to fall after a wide comparison. That appears on the lock port a single cycle after the comparison that settles it. A selector decode fault appears on the monitor pin in the same cycle the code is applied, which is why every code is swept against several input level patterns.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef enum logic [3:0] {
    MON_ZERO  = 4'd0,
    MON_LK1   = 4'd1,
    MON_LK2   = 4'd2,
    MON_LKB   = 4'd3,
    MON_REF1  = 4'd4,
    MON_REF2  = 4'd5,
    MON_FB1   = 4'd6,
    MON_FB2   = 4'd7,
    MON_SDO   = 4'd8,
    MON_CLR   = 4'd9
  } mon_src_e;

  // Selector decode; bit order {s3,s2,s1,s0} is what the register file writes.
  function automatic mon_src_e decode_sel(input logic [3:0] s);
    mon_src_e r;
    casez (s)
      4'b0100: r = MON_LK1;
      4'b0001: r = MON_LK2;
      4'b0101: r = MON_LKB;
      4'b1?00: r = MON_REF1;
      4'b0?10: r = MON_REF2;
      4'b1?01: r = MON_FB1;
      4'b0?11: r = MON_FB2;
      4'b1010: r = MON_SDO;
      4'b1111: r = MON_CLR;
      default: r = MON_ZERO;
    endcase
    return r;
  endfunction

  // A comparison is good when its error pulse fits in the window.
  function automatic logic width_ok(input int unsigned w, input int unsigned win);
    return (w <= win);
  endfunction

endpackage

// File: rtl/pfd_channel.sv
module pfd_channel #(
  parameter int CW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_in,
  input  logic        fb_in,
  input  logic        pol,
  input  logic        hiz,
  input  logic        off,
  output logic        src,
  output logic        snk,
  output logic        up_o,
  output logic        dn_o,
  output logic        ref_lvl,
  output logic        fb_lvl,
  output logic        cmp_done,
  output logic [CW:0] width
);

  localparam logic [CW-1:0] WMAX = {CW{1'b1}};

  logic ref_q, ref_d, fb_q, fb_d;
  logic up_q, dn_q;
  logic [CW-1:0] wcnt;
  logic ref_rise, fb_rise, up_set, dn_set, pair, active, drive;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      ref_d <= 1'b0;
      fb_q  <= 1'b0;
      fb_d  <= 1'b0;
    end else begin
      ref_q <= ref_in;
      ref_d <= ref_q;
      fb_q  <= fb_in;
      fb_d  <= fb_q;
    end
  end

  assign ref_rise = ref_q & ~ref_d;
  assign fb_rise  = fb_q & ~fb_d;
  assign up_set   = up_q | ref_rise;
  assign dn_set   = dn_q | fb_rise;
  assign pair     = up_set & dn_set;
  assign active   = up_q | dn_q;

  always_ff @(posedge clk) begin
    if (!rst_n || off) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (pair) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_set;
      dn_q <= dn_set;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || off || pair) begin
      wcnt <= '0;
    end else if (active && wcnt != WMAX) begin
      wcnt <= wcnt + 1'b1;
    end
  end

  assign width    = {1'b0, wcnt} + {{CW{1'b0}}, active};
  assign cmp_done = pair & ~off;
  assign drive    = ~hiz & ~off;
  assign src      = drive & (pol ? up_q : dn_q);
  assign snk      = drive & (pol ? dn_q : up_q);
  assign up_o     = up_q;
  assign dn_o     = dn_q;
  assign ref_lvl  = ref_q;
  assign fb_lvl   = fb_q;

  // R1: up and down latches never stay set together
  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_q && dn_q));

  // R1: a pending up pulse ends when the feedback edge arrives
  a_r1_pair_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && fb_rise) |=> (!up_q && !dn_q));

  // R4: power-down clears the comparison state
  a_r4_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> (!up_q && !dn_q));

endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det
  import pfd_pkg::*;
#(
  parameter int CW       = 8,
  parameter int LOCK_WIN = 2,
  parameter int LOCK_CNT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        off,
  input  logic        cmp_done,
  input  logic [CW:0] width,
  input  logic        pulse_act,
  output logic        lock_out
);

  localparam int NW = $clog2(LOCK_CNT + 1);
  localparam logic [NW-1:0] NMAX = NW'(LOCK_CNT);

  logic [NW-1:0] good_cnt, cnt_inc;
  logic          locked_q, good;

  assign good    = width_ok(int'(width), LOCK_WIN);
  assign cnt_inc = (good_cnt == NMAX) ? good_cnt : good_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || off) begin
      good_cnt <= '0;
      locked_q <= 1'b0;
    end else if (cmp_done) begin
      if (good) begin
        good_cnt <= cnt_inc;
        locked_q <= (cnt_inc == NMAX);
      end else begin
        good_cnt <= '0;
        locked_q <= 1'b0;
      end
    end
  end

  assign lock_out = locked_q & ~pulse_act;

  // R5: lock only rises on the edge that closes a comparison
  a_r5_rise_on_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(cmp_done));

  // R6: a wide comparison always removes lock
  a_r6_wide_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_done && !good) |=> !locked_q);

endmodule

// File: rtl/pfd_monitor.sv
module pfd_monitor
  import pfd_pkg::*;
(
  input  logic [3:0] sel,
  input  logic [1:0] lk,
  input  logic [1:0] ref_lvl,
  input  logic [1:0] fb_lvl,
  input  logic       sdo,
  input  logic       all_off,
  output logic       mon,
  output logic       clr
);

  mon_src_e src;
  logic     pick;

  assign src = decode_sel(sel);

  always_comb begin
    case (src)
      MON_LK1:  pick = lk[0];
      MON_LK2:  pick = lk[1];
      MON_LKB:  pick = lk[0] & lk[1];
      MON_REF1: pick = ref_lvl[0];
      MON_REF2: pick = ref_lvl[1];
      MON_FB1:  pick = fb_lvl[0];
      MON_FB2:  pick = fb_lvl[1];
      MON_SDO:  pick = sdo;
      default:  pick = 1'b0;
    endcase
  end

  assign mon = pick & ~all_off;
  assign clr = (src == MON_CLR);

endmodule

// File: rtl/pfd_lock_monitor.sv
module pfd_lock_monitor #(
  parameter int LOCK_WIN  = 2,
  parameter int LOCK_CNT  = 4,
  parameter int WIDTH_SAT = 255
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref1_in,
  input  logic       fb1_in,
  input  logic       ref2_in,
  input  logic       fb2_in,
  input  logic       ch1_pol,
  input  logic       ch1_hiz,
  input  logic       ch1_off,
  input  logic       ch2_pol,
  input  logic       ch2_hiz,
  input  logic       ch2_off,
  input  logic [3:0] mon_sel,
  input  logic       shift_dout,
  output logic       ch1_src,
  output logic       ch1_snk,
  output logic       ch2_src,
  output logic       ch2_snk,
  output logic       ch1_lock,
  output logic       ch2_lock,
  output logic       mon_out,
  output logic       cnt_clear_req,
  output logic       ref_run
);

  localparam int NCH = 2;
  localparam int CW  = $clog2(WIDTH_SAT + 1);

  logic [NCH-1:0] ref_w, fb_w, pol_w, hiz_w, off_w;
  logic [NCH-1:0] src_w, snk_w, up_w, dn_w, rlvl_w, flvl_w, done_w, lk_w;
  logic [CW:0]    width_w [NCH];
  logic           all_off;

  assign ref_w = {ref2_in, ref1_in};
  assign fb_w  = {fb2_in, fb1_in};
  assign pol_w = {ch2_pol, ch1_pol};
  assign hiz_w = {ch2_hiz, ch1_hiz};
  assign off_w = {ch2_off, ch1_off};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pfd_channel #(.CW(CW)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_in   (ref_w[g]),
      .fb_in    (fb_w[g]),
      .pol      (pol_w[g]),
      .hiz      (hiz_w[g]),
      .off      (off_w[g]),
      .src      (src_w[g]),
      .snk      (snk_w[g]),
      .up_o     (up_w[g]),
      .dn_o     (dn_w[g]),
      .ref_lvl  (rlvl_w[g]),
      .fb_lvl   (flvl_w[g]),
      .cmp_done (done_w[g]),
      .width    (width_w[g])
    );

    pfd_lock_det #(.CW(CW), .LOCK_WIN(LOCK_WIN), .LOCK_CNT(LOCK_CNT)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .off       (off_w[g]),
      .cmp_done  (done_w[g]),
      .width     (width_w[g]),
      .pulse_act (up_w[g] | dn_w[g]),
      .lock_out  (lk_w[g])
    );

    // R7: the lock indication dips while an error pulse is active
    a_r7_dip_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (up_w[g] || dn_w[g]) |-> !lk_w[g]);

    // R3: a tri-stated or powered-down channel requests nothing
    a_r3_quiet_requests: assert property (@(posedge clk) disable iff (!rst_n)
      (hiz_w[g] || off_w[g]) |-> !(src_w[g] || snk_w[g]));
  end

  assign all_off = &off_w;

  pfd_monitor u_mon (
    .sel     (mon_sel),
    .lk      (lk_w),
    .ref_lvl (rlvl_w),
    .fb_lvl  (flvl_w),
    .sdo     (shift_dout),
    .all_off (all_off),
    .mon     (mon_out),
    .clr     (cnt_clear_req)
  );

  assign ch1_src  = src_w[0];
  assign ch1_snk  = snk_w[0];
  assign ch2_src  = src_w[1];
  assign ch2_snk  = snk_w[1];
  assign ch1_lock = lk_w[0];
  assign ch2_lock = lk_w[1];
  assign ref_run  = ~all_off;

  // R10: with both channels down the monitor pin stays low
  a_r10_mon_low_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ch1_off && ch2_off) |-> !mon_out);

  // R9: reserved, disabled and reset codes never drive the pin high
  a_r9_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_sel == 4'b0000 || mon_sel == 4'b1011 || mon_sel == 4'b1110 ||
     mon_sel == 4'b1111) |-> !mon_out);

endmodule

// File: tb/pfd_lock_monitor_test.sv
module pfd_lock_monitor_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ref_b = '0, fb_b = '0, pol_b = '0, hiz_b = '0, off_b = '0;
  logic [3:0] sel = '0;
  logic sdo = 1'b0;
  logic ch1_src, ch1_snk, ch2_src, ch2_snk, ch1_lock, ch2_lock;
  logic mon_out, cnt_clear_req, ref_run;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pfd_lock_monitor uut (
    .clk(clk), .rst_n(rst_n),
    .ref1_in(ref_b[0]), .fb1_in(fb_b[0]), .ref2_in(ref_b[1]), .fb2_in(fb_b[1]),
    .ch1_pol(pol_b[0]), .ch1_hiz(hiz_b[0]), .ch1_off(off_b[0]),
    .ch2_pol(pol_b[1]), .ch2_hiz(hiz_b[1]), .ch2_off(off_b[1]),
    .mon_sel(sel), .shift_dout(sdo),
    .ch1_src(ch1_src), .ch1_snk(ch1_snk), .ch2_src(ch2_src), .ch2_snk(ch2_snk),
    .ch1_lock(ch1_lock), .ch2_lock(ch2_lock),
    .mon_out(mon_out), .cnt_clear_req(cnt_clear_req), .ref_run(ref_run)
  );

  task automatic check(input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic logic lock_of(input int ch);
    return (ch == 0) ? ch1_lock : ch2_lock;
  endfunction

  // Drive one comparison: d > 0 reference leads by d cycles, d < 0 feedback leads.
  task automatic pulse_pair(input int ch, input int d,
                            output int n_src, output int n_snk, output int n_dip);
    int ad;
    ad = (d < 0) ? -d : d;
    n_src = 0; n_snk = 0; n_dip = 0;
    for (int i = 0; i <= ad + 8; i++) begin
      @(negedge clk);
      if (i > 0) begin
        if ((ch == 0) ? ch1_src : ch2_src) n_src++;
        if ((ch == 0) ? ch1_snk : ch2_snk) n_snk++;
        if (!lock_of(ch)) n_dip++;
      end
      if (i == 0) begin
        if (d >= 0) ref_b[ch] = 1'b1;
        if (d <= 0) fb_b[ch] = 1'b1;
      end
      if (i == ad && d > 0) fb_b[ch] = 1'b1;
      if (i == ad && d < 0) ref_b[ch] = 1'b1;
      if (i == ad + 4) begin
        ref_b[ch] = 1'b0;
        fb_b[ch] = 1'b0;
      end
    end
  endtask

  task automatic relock(input int ch);
    int a, b, c;
    for (int k = 0; k < 4; k++) pulse_pair(ch, 0, a, b, c);
  endtask

  task automatic set_levels(input logic r1, input logic f1, input logic r2,
                            input logic f2, input logic s);
    @(negedge clk);
    ref_b = {r2, r1};
    fb_b  = {f2, f1};
    sdo   = s;
    repeat (3) @(negedge clk);
  endtask

  // Expected monitor value, worked out from the selector bits.
  function automatic logic mon_expect(input logic [3:0] s, input logic l1, input logic l2,
                                      input logic s_d);
    if (s == 4'b0000 || s == 4'b1111 || s == 4'b1011 || s == 4'b1110) return 1'b0;
    if (s == 4'b1010) return s_d;
    if (!s[3] && !s[1]) begin
      if (s[2] && s[0]) return l1 & l2;
      return s[2] ? l1 : l2;
    end
    case (s[1:0])
      2'b00:   return ref_b[0];
      2'b10:   return ref_b[1];
      2'b01:   return fb_b[0];
      default: return fb_b[1];
    endcase
  endfunction

  task automatic sweep_sel(input string tag, input logic all_down);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      sel = 4'(c);
      #1;
      if (all_down)
        check(int'(mon_out), 0, $sformatf("R10 sel=%0d %s", c, tag));
      else
        check(int'(mon_out), int'(mon_expect(4'(c), ch1_lock, ch2_lock, sdo)),
              $sformatf("R8 R9 sel=%0d %s", c, tag));
      check(int'(cnt_clear_req), (c == 15) ? 1 : 0, $sformatf("R9 clear sel=%0d", c));
    end
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int s_n, k_n, d_n, e_src, e_snk;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(int'(ch1_src | ch1_snk | ch2_src | ch2_snk), 0, "R1 reset requests");
    check(int'(ch1_lock | ch2_lock), 0, "R5 reset lock");
    check(int'(mon_out), 0, "R9 reset monitor");
    check(int'(ref_run), 1, "R10 ref_run with channels on");

    // R1/R2: widths and polarity over both channels
    for (int ch = 0; ch < 2; ch++) begin
      for (int p = 0; p < 2; p++) begin
        pol_b[ch] = p[0];
        for (int d = -3; d <= 3; d++) begin
          pulse_pair(ch, d, s_n, k_n, d_n);
          e_src = p[0] ? ((d > 0) ? d : 0) : ((d < 0) ? -d : 0);
          e_snk = p[0] ? ((d < 0) ? -d : 0) : ((d > 0) ? d : 0);
          check(s_n, e_src, $sformatf("R1 R2 src ch%0d pol%0d d=%0d", ch, p, d));
          check(k_n, e_snk, $sformatf("R1 R2 snk ch%0d pol%0d d=%0d", ch, p, d));
        end
      end
    end
    pol_b = 2'b11;

    // R5: lock after four good comparisons
    pulse_pair(0, 5, s_n, k_n, d_n);
    for (int k = 0; k < 3; k++) pulse_pair(0, 1, s_n, k_n, d_n);
    check(int'(ch1_lock), 0, "R5 lock after three good");
    pulse_pair(0, -2, s_n, k_n, d_n);
    check(int'(ch1_lock), 1, "R5 lock after four good");
    // R7: dip width equals pulse width
    pulse_pair(0, 2, s_n, k_n, d_n);
    check(d_n, 2, "R7 dip cycles d=2");
    check(int'(ch1_lock), 1, "R7 lock held after narrow pulse");
    pulse_pair(0, 0, s_n, k_n, d_n);
    check(d_n, 0, "R7 no dip for aligned edges");
    // R6: wide comparison drops lock and restarts count
    pulse_pair(0, -5, s_n, k_n, d_n);
    check(int'(ch1_lock), 0, "R6 lock lost after wide");
    for (int k = 0; k < 3; k++) pulse_pair(0, 0, s_n, k_n, d_n);
    check(int'(ch1_lock), 0, "R6 three good after wide");
    pulse_pair(0, 1, s_n, k_n, d_n);
    check(int'(ch1_lock), 1, "R6 relock on fourth");

    // R3: tri-state silences requests
    hiz_b[0] = 1'b1;
    pulse_pair(0, 3, s_n, k_n, d_n);
    check(s_n + k_n, 0, "R3 hiz ref leads");
    pulse_pair(0, -3, s_n, k_n, d_n);
    check(s_n + k_n, 0, "R3 hiz fb leads");
    hiz_b[0] = 1'b0;

    // R4: power-down
    relock(1);
    check(int'(ch2_lock), 1, "R4 ch2 locked before off");
    off_b[1] = 1'b1;
    pulse_pair(1, 2, s_n, k_n, d_n);
    check(s_n + k_n, 0, "R4 off requests");
    check(int'(ch2_lock), 0, "R4 off lock");
    off_b[1] = 1'b0;
    for (int k = 0; k < 3; k++) pulse_pair(1, 0, s_n, k_n, d_n);
    check(int'(ch2_lock), 0, "R4 count restarted after power-up");
    pulse_pair(1, 0, s_n, k_n, d_n);
    check(int'(ch2_lock), 1, "R4 relock after power-up");

    // R8/R9: monitor selector sweeps
    relock(0);
    relock(1);
    set_levels(1, 1, 1, 1, 0);
    check(int'(ch1_lock & ch2_lock), 1, "R8 both locked before sweep");
    sweep_sel("all high", 1'b0);
    set_levels(1, 0, 0, 1, 1);
    sweep_sel("pattern A", 1'b0);
    set_levels(0, 1, 1, 0, 0);
    sweep_sel("pattern B", 1'b0);

    // R10: both channels powered down
    set_levels(1, 1, 1, 1, 1);
    off_b = 2'b11;
    @(negedge clk);
    check(int'(ref_run), 0, "R10 ref_run both off");
    sweep_sel("both off", 1'b1);
    off_b = 2'b01;
    @(negedge clk);
    check(int'(ref_run), 1, "R10 ref_run one on");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule